// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave device on a two-wire serial bus built from a clock line and an open-drain data line. It holds a small byte array and a single address pointer that reads and writes share. A master opens a transfer with a start condition and an address byte. The top seven bits of that byte must equal the configured device address. The lowest bit selects the direction: 0 writes and 1 reads. A write carries one byte that loads the pointer, followed by any number of data bytes. A read returns the byte at the pointer at once and keeps returning bytes for as long as the master acknowledges them. To read from a chosen location, the master loads the pointer with a write that carries no data, then issues a repeated start and reads.

Both bus lines are synchronised into the system clock. A detector turns their edges into four events: clock rise, clock fall, start and stop. A state machine uses these events to move through its states:

- S_IDLE waits for a start.
- S_DEV_ADDR shifts in the address byte. A match leads to S_DEV_ACK; a mismatch leads to S_IGNORE.
- S_DEV_ACK leads to S_RD_DATA when the direction bit is 1 and to S_WORD_ADDR when it is 0.
- S_WORD_ADDR leads to S_WORD_ACK, which leads to S_WR_DATA.
- S_WR_DATA and S_WR_ACK alternate, one pair per data byte.
- S_RD_DATA leads to S_RD_ACK. From there the machine returns to S_RD_DATA when the master acknowledges and goes to S_IGNORE when it does not.

A start from any state leads to S_DEV_ADDR, and a stop from any state leads to S_IDLE.

Top module: `twi_mem_slave`

## Requirements
- R1: The slave acknowledges an address byte only when bits 7:1 equal DEV_ADDR, by pulling SDA low during the ninth clock. On a mismatch it gives no acknowledge and leaves SDA released for every later clock until the next start.
- R2: In a write (address byte bit 0 = 0), the second byte loads the pointer with its low AW bits. Every later complete data byte is stored at the pointer, is acknowledged, and advances the pointer by one.
- R3: A read that begins without loading the pointer returns the byte at the pointer. After a write, the pointer is one past the last stored byte. After a read, it is one past the last byte read.
- R4: A random read is a start, the address byte with bit 0 = 0, a pointer byte, a repeated start, and the address byte with bit 0 = 1. It returns the byte at the loaded location and writes nothing.
- R5: When the master pulls SDA low on the ninth clock of a read byte, the slave sends the next byte. The pointer wraps from 2^AW-1 to 0.
- R6: When the master leaves SDA high on the ninth clock of a read byte, the slave releases SDA and drives nothing until the next start or stop.
- R7: A stop issued in the ninth clock of a read byte ends the read. SDA stays released, and the pointer stays one past the byte just sent.
- R8: Read data leaves most significant bit first. The slave's SDA drive changes only while SCL is low.
- R9: A start or stop at any bit position resets the bit count and the state machine without changing the pointer. A data byte cut short by either is not stored.
- R10: After reset, SDA is released, the machine is in S_IDLE, and the pointer is 0. The array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | High pulls SDA low; low releases it |

## Verification
Several corner cases are targeted, each with the failure it would expose. A multi-byte write and an acknowledged read both cross the top of the array; a pointer that saturated or failed to wrap would return the wrong tail bytes. Stops placed in three spots test the pointer: one in the ninth clock of a read, one inside a half-sent data byte, and one after a bare pointer load. A design that wrote partial bytes, or lost or moved the pointer on a stop, would return stale or shifted data. The bench also clocks a full byte after a not-acknowledge and after an address mismatch; a slave that did not go silent there would pull the line low. A reset in the middle of the run checks that the pointer returns to 0 while the stored bytes survive.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV_ADDR,
        S_DEV_ACK,
        S_WORD_ADDR,
        S_WORD_ACK,
        S_WR_DATA,
        S_WR_ACK,
        S_RD_DATA,
        S_RD_ACK,
        S_IGNORE
    } twi_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twi_byte_ram.sv
module twi_byte_ram #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
    import twi_mem_pkg::*;
#(
    parameter int         AW       = 4,
    parameter logic [6:0] DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output twi_state_e        state,
    output logic [AW-1:0]     addr_cnt,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              sda_oe
);

    localparam logic [3:0] BITS_DONE = 4'(BYTE_W);

    twi_state_e        nxt;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              master_ack;
    logic              byte_done;
    logic              dev_match;

    assign byte_done = (bit_cnt == BITS_DONE) & scl_fall;
    assign dev_match = (rx_sh[7:1] == DEV_ADDR);
    assign mem_we    = (state == S_WR_DATA) & byte_done & ~start_det & ~stop_det;
    assign mem_wdata = rx_sh;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = S_DEV_ADDR;
        end else if (stop_det) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:      nxt = S_IDLE;
                S_DEV_ADDR:  if (byte_done) nxt = dev_match ? S_DEV_ACK : S_IGNORE;
                S_DEV_ACK:   if (scl_fall) nxt = rx_sh[0] ? S_RD_DATA : S_WORD_ADDR;
                S_WORD_ADDR: if (byte_done) nxt = S_WORD_ACK;
                S_WORD_ACK:  if (scl_fall) nxt = S_WR_DATA;
                S_WR_DATA:   if (byte_done) nxt = S_WR_ACK;
                S_WR_ACK:    if (scl_fall) nxt = S_WR_DATA;
                S_RD_DATA:   if (byte_done) nxt = S_RD_ACK;
                S_RD_ACK:    if (scl_fall) nxt = master_ack ? S_RD_DATA : S_IGNORE;
                S_IGNORE:    nxt = S_IGNORE;
                default:     nxt = S_IDLE;
            endcase
        end
    end

    // datapath and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            master_ack <= 1'b0;
            addr_cnt   <= '0;
            sda_oe     <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
            sda_oe  <= 1'b0;
        end else begin
            unique case (state)
                S_DEV_ADDR, S_WORD_ADDR, S_WR_DATA: begin
                    if (scl_rise) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        sda_oe  <= (state != S_DEV_ADDR) || dev_match;
                        if (state == S_WORD_ADDR) begin
                            addr_cnt <= rx_sh[AW-1:0];
                        end
                        if (state == S_WR_DATA) begin
                            addr_cnt <= addr_cnt + 1'b1;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rx_sh[0]) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                S_WORD_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                    end
                end
                S_RD_DATA: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (scl_fall) begin
                        if (bit_cnt == BITS_DONE) begin
                            bit_cnt  <= '0;
                            sda_oe   <= 1'b0;
                            addr_cnt <= addr_cnt + 1'b1;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end
                    if (scl_fall) begin
                        if (master_ack) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                default: begin
                    sda_oe <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         AW          = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    logic              scl_s;
    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    twi_state_e        state;
    logic [AW-1:0]     addr_cnt;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_wdata;
    logic [BYTE_W-1:0] rd_data;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_link_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .state     (state),
        .addr_cnt  (addr_cnt),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .sda_oe    (sda_oe)
    );

    twi_byte_ram #(.AW(AW), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (addr_cnt),
        .wdata (mem_wdata),
        .raddr (addr_cnt),
        .rdata (rd_data)
    );

endmodule

// File: rtl/twi_mem_checker.sv
module twi_mem_checker
    import twi_mem_pkg::*;
#(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe,
    input twi_state_e    state,
    input logic [AW-1:0] addr_cnt,
    input logic          mem_we
);

    assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == S_DEV_ADDR));

    assert_pointer_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |=> $stable(addr_cnt));

    assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == S_IDLE && !sda_oe));

    assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IGNORE) |-> !sda_oe);

    assert_write_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (state == S_WR_ACK && addr_cnt == $past(addr_cnt) + AW'(1)));

endmodule

bind twi_mem_slave twi_mem_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .state     (state),
    .addr_cnt  (addr_cnt),
    .mem_we    (mem_we)
);

// File: tb/tb_twi_mem_slave.sv
module tb_twi_mem_slave;

    localparam int         AW    = 4;
    localparam int         DEPTH = 1 << AW;
    localparam logic [6:0] DEV   = 7'h50;
    localparam logic [7:0] DEV_W = {DEV, 1'b0};
    localparam logic [7:0] DEV_R = {DEV, 1'b1};

    // {pointer, data}: write once, read back at random
    localparam logic [15:0] VEC [6] = '{16'h023C, 16'h05A5, 16'h0781,
                                        16'h0907, 16'h0BF0, 16'h03C3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic dut_oe;
    wire  sda_bus = m_sda & ~dut_oe;

    int checks = 0;
    int errors = 0;
    int oe_hi_changes = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [DEPTH];
    logic [AW-1:0] ptr;

    always #5 clk = ~clk;

    twi_mem_slave #(.DEV_ADDR(DEV), .AW(AW)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (dut_oe)
    );

    always @(posedge clk) begin
        if (rst_n && m_scl && (dut_oe != oe_prev)) oe_hi_changes++;
        oe_prev <= dut_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b0; tick(8);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(5);
        m_scl = 1'b1; tick(8);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(5);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(5);
        m_scl = 1'b1; tick(4);
        ack = ~sda_bus; tick(4);
        m_scl = 1'b0; tick(5);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] d);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(5);
            m_scl = 1'b1; tick(4);
            d = {d[6:0], sda_bus}; tick(4);
            m_scl = 1'b0;
        end
        tick(2);
        m_sda = ~give_ack; tick(3);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(5);
        m_sda = 1'b1;
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack); check("R1 address ack", 16'(ack), 16'h1);
        send_byte(a, ack);     check("R2 pointer ack", 16'(ack), 16'h1);
        send_byte(d, ack);     check("R2 data ack", 16'(ack), 16'h1);
        bus_stop();
        model[a[AW-1:0]] = d;
        ptr = a[AW-1:0] + 1'b1;
    endtask

    task automatic load_ptr_and_read(input logic [7:0] a, input logic give_ack, output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(a, ack);
        bus_start();
        send_byte(DEV_R, ack); check("R4 read address ack", 16'(ack), 16'h1);
        read_byte(give_ack, d);
        ptr = a[AW-1:0] + 1'b1;
    endtask

    initial begin
        logic [7:0] d;
        logic ack;
        tick(4);
        check("R10 released in reset", 16'(dut_oe), 16'h0);
        rst_n = 1'b1;
        tick(4);
        check("R10 released after reset", 16'(sda_bus), 16'h1);
        ptr = '0;

        // vector walk: write then random read back (R2, R4, R8 bit order)
        for (int v = 0; v < 6; v++) begin
            write_one(VEC[v][15:8], VEC[v][7:0]);
            load_ptr_and_read(VEC[v][15:8], 1'b0, d);
            bus_stop();
            check("R4 R8 random read data", 16'(d), 16'(VEC[v][7:0]));
        end

        // R1: mismatched address, then a further byte stays unacknowledged
        bus_start();
        send_byte({7'h51, 1'b0}, ack); check("R1 mismatch no ack", 16'(ack), 16'h0);
        send_byte(8'h00, ack);         check("R1 ignored until start", 16'(ack), 16'h0);
        bus_stop();

        // R2/R5: multi-byte write across the top of the array
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h0E, ack);
        for (int k = 0; k < 4; k++) begin
            send_byte(8'h61 + 8'(k), ack);
            check("R2 burst data ack", 16'(ack), 16'h1);
            model[4'hE + 4'(k)] = 8'h61 + 8'(k);
        end
        bus_stop();

        // R5: sequential read with wrap
        load_ptr_and_read(8'h0E, 1'b1, d);
        check("R5 sequential byte 0", 16'(d), 16'(model[4'hE]));
        for (int k = 1; k < 4; k++) begin
            read_byte(k != 3, d);
            check("R5 sequential wrap", 16'(d), 16'(model[4'hE + 4'(k)]));
        end
        bus_stop();
        ptr = 4'h2;

        // R3: current read after a read
        bus_start();
        send_byte(DEV_R, ack);
        read_byte(1'b0, d);
        bus_stop();
        check("R3 current after read", 16'(d), 16'(model[ptr]));

        // R3: current read after a write
        write_one(8'h0A, 8'h77);
        bus_start();
        send_byte(DEV_R, ack);
        read_byte(1'b0, d);
        bus_stop();
        check("R3 current after write", 16'(d), 16'(model[ptr]));

        // R6: not-acknowledge then slave silent for a whole byte
        load_ptr_and_read(8'h07, 1'b0, d);
        check("R6 data before nack", 16'(d), 16'(model[7]));
        read_byte(1'b0, d);
        check("R6 silent after nack", 16'(d), 16'hFF);
        bus_stop();

        // R7: stop in ninth clock of a read
        load_ptr_and_read(8'h02, 1'b0, d);
        check("R7 data before stop", 16'(d), 16'(model[2]));
        // read_byte already drove the ninth clock; redo with a stop inside it
        load_ptr_and_read(8'h02, 1'b1, d);
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h02, ack);
        bus_start();
        send_byte(DEV_R, ack);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(5); m_scl = 1'b1; tick(4);
            d = {d[6:0], sda_bus}; tick(4); m_scl = 1'b0;
        end
        tick(2); m_sda = 1'b0; tick(3);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(8);
        check("R7 released after stop", 16'(sda_bus), 16'h1);
        bus_start();
        send_byte(DEV_R, ack);
        read_byte(1'b0, d);
        bus_stop();
        check("R7 pointer after stop", 16'(d), 16'(model[3]));

        // R9: data byte cut short by stop is not stored, pointer kept
        bus_start();
        send_byte(DEV_W, ack);
        send_byte(8'h09, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        bus_start();
        send_byte(DEV_R, ack);
        read_byte(1'b0, d);
        bus_stop();
        check("R9 partial byte dropped", 16'(d), 16'(model[9]));

        // R10: reset clears pointer, keeps array
        rst_n = 1'b0; tick(4);
        rst_n = 1'b1; tick(4);
        bus_start();
        send_byte(DEV_R, ack);
        read_byte(1'b0, d);
        bus_stop();
        check("R10 pointer zero after reset", 16'(d), 16'(model[0]));

        check("R8 drive changes only with SCL low", 16'(oe_hi_changes), 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule